// File: doc/BRIEF.md
# Big-Endian Load Data Aligner

This block produces the value a load writes back into its destination register on a 32-bit big-endian core. Each cycle it may take the load opcode, the two low bits of the effective address (base register plus sign-extended 16-bit offset, formed upstream), the aligned memory word fetched from the address with its low two bits cleared, and the current contents of the destination register. From these it returns the write-back value and a flag that marks an access that is not naturally aligned.

It handles signed and unsigned byte and halfword loads, full-word loads, and the load-linked form, which this block treats as a plain word load. It also handles the two partial-word loads that merge part of the memory word into the old register contents. These let software assemble an unaligned word in two steps. The results are registered: a request marked by `in_valid` shows up on the outputs one clock later, qualified by `out_valid`.

Top module: `ld_align_be`

## Requirements
- R1: A synchronous active-high reset clears `out_valid`, `wr_data` and `misalign` to zero.
- R2: Each cycle with `in_valid` high gives a result on the next clock edge with `out_valid` high. A cycle with `in_valid` low gives `out_valid` low on the next edge.
- R3: Opcode 32 (signed byte) picks a byte by big-endian lane order and sign-extends it. Address offset 0 picks bits 31:24, 1 picks 23:16, 2 picks 15:8 and 3 picks 7:0.
- R4: Opcode 36 (unsigned byte) picks the same lane as R3 and zero-extends it.
- R5: Opcode 33 (signed halfword) picks bits 31:16 when address bit 1 is 0 and bits 15:0 when it is 1, and sign-extends the result. Address bit 0 does not affect the data.
- R6: Opcode 37 (unsigned halfword) picks the same halfword as R5 and zero-extends it.
- R7: Opcodes 35 (word) and 48 (load-linked) return the whole memory word at every offset.
- R8: Opcode 34 (left merge) with offset k returns the memory word shifted left by 8*k bits, with the low 8*k bits taken from the old register. Offset 0 returns the whole word.
- R9: Opcode 38 (right merge) with offset 0 returns the old register unchanged. With offset k>0 it returns the memory word shifted right by 32-8*k bits, with the upper 32-8*k bits kept from the old register.
- R10: `misalign` is high for opcodes 33 and 37 when address bit 0 is set, and for opcodes 35 and 48 when either low address bit is set. It is low for every other case.
- R11: Any other opcode returns the old register value unchanged, with `misalign` low.
- R12: While `in_valid` is low, `wr_data` and `misalign` keep their last values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A load request is present this cycle |
| op | input | 6 | Primary opcode of the load |
| addr_lo | input | 2 | Low two bits of the effective address |
| mem_word | input | 32 | Aligned memory word |
| old_rt | input | 32 | Current destination register value |
| out_valid | output | 1 | Registered result is valid |
| wr_data | output | 32 | Value to write into the destination register |
| misalign | output | 1 | Access is not naturally aligned |

## Verification
The checker watches several things on every cycle:
- the one-cycle valid timing;
- that `wr_data` and `misalign` hold while `in_valid` is low;
- that `misalign` is never raised for opcodes outside the halfword and word group;
- the zero upper bits of unsigned byte results and the replicated sign of signed byte results;
- the two fixed endpoints of the merges: a left merge at offset 0 returns the memory word, and a right merge at offset 0 returns the old register.

Only the bench scenarios can show the exact lane chosen for each offset and the byte-exact merge boundaries at offsets 1 to 3. They do this by sweeping every opcode across all four offsets with varied memory and register patterns. The bench also exercises the undefined-opcode pass-through.

// File: rtl/ld_align_pkg.sv
package ld_align_pkg;
  localparam int OP_W = 6;

  localparam logic [OP_W-1:0] OPC_BYTE_S  = 6'd32;
  localparam logic [OP_W-1:0] OPC_HALF_S  = 6'd33;
  localparam logic [OP_W-1:0] OPC_LEFT    = 6'd34;
  localparam logic [OP_W-1:0] OPC_WORD    = 6'd35;
  localparam logic [OP_W-1:0] OPC_BYTE_U  = 6'd36;
  localparam logic [OP_W-1:0] OPC_HALF_U  = 6'd37;
  localparam logic [OP_W-1:0] OPC_RIGHT   = 6'd38;
  localparam logic [OP_W-1:0] OPC_LINKED  = 6'd48;

  typedef enum logic [2:0] {
    KIND_PASS  = 3'd0,
    KIND_BYTE  = 3'd1,
    KIND_HALF  = 3'd2,
    KIND_WORD  = 3'd3,
    KIND_LEFT  = 3'd4,
    KIND_RIGHT = 3'd5
  } ld_kind_e;
endpackage

// File: rtl/ld_decode.sv
module ld_decode
  import ld_align_pkg::*;
#(
  parameter int OFS_W = 2
) (
  input  logic [OP_W-1:0]  op,
  input  logic [OFS_W-1:0] ofs,
  output ld_kind_e         kind,
  output logic             sign_ext,
  output logic             misalign
);
  always_comb begin
    kind     = KIND_PASS;
    sign_ext = 1'b0;
    unique case (op)
      OPC_BYTE_S: begin kind = KIND_BYTE; sign_ext = 1'b1; end
      OPC_BYTE_U: kind = KIND_BYTE;
      OPC_HALF_S: begin kind = KIND_HALF; sign_ext = 1'b1; end
      OPC_HALF_U: kind = KIND_HALF;
      OPC_WORD, OPC_LINKED: kind = KIND_WORD;
      OPC_LEFT:   kind = KIND_LEFT;
      OPC_RIGHT:  kind = KIND_RIGHT;
      default:    kind = KIND_PASS;
    endcase
  end

  always_comb begin
    misalign = 1'b0;
    if (kind == KIND_HALF) misalign = ofs[0];
    else if (kind == KIND_WORD) misalign = |ofs;
  end
endmodule

// File: rtl/ld_lane_pick.sv
module ld_lane_pick #(
  parameter int DATA_W = 32,
  localparam int NB    = DATA_W / 8,
  localparam int NH    = NB / 2,
  localparam int OFS_W = $clog2(NB)
) (
  input  logic [DATA_W-1:0] word,
  input  logic [OFS_W-1:0]  ofs,
  output logic [7:0]        byte_o,
  output logic [15:0]       half_o
);
  logic [7:0]  blane [NB];
  logic [15:0] hlane [NH];

  for (genvar g = 0; g < NB; g++) begin : g_byte
    assign blane[g] = word[DATA_W-1-8*g -: 8];
  end
  for (genvar g = 0; g < NH; g++) begin : g_half
    assign hlane[g] = word[DATA_W-1-16*g -: 16];
  end

  assign byte_o = blane[ofs];
  assign half_o = hlane[ofs[OFS_W-1:1]];
endmodule

// File: rtl/ld_partial_merge.sv
module ld_partial_merge #(
  parameter int DATA_W = 32,
  localparam int NB    = DATA_W / 8,
  localparam int OFS_W = $clog2(NB),
  localparam int SH_W  = OFS_W + 3
) (
  input  logic [DATA_W-1:0] word,
  input  logic [DATA_W-1:0] old_v,
  input  logic [OFS_W-1:0]  ofs,
  output logic [DATA_W-1:0] left_o,
  output logic [DATA_W-1:0] right_o
);
  logic [SH_W-1:0]   sh_up;
  logic [SH_W-1:0]   sh_dn;
  logic [DATA_W-1:0] keep_lo;

  assign sh_up   = {ofs, 3'b000};
  assign sh_dn   = SH_W'(DATA_W) - sh_up;
  assign keep_lo = ~({DATA_W{1'b1}} << sh_up);

  assign left_o  = (word << sh_up) | (old_v & keep_lo);
  assign right_o = (ofs == '0) ? old_v
                               : ((word >> sh_dn) | (old_v & ~keep_lo));
endmodule

// File: rtl/ld_align_be.sv
module ld_align_be
  import ld_align_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NB    = DATA_W / 8,
  localparam int OFS_W = $clog2(NB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   op,
  input  logic [OFS_W-1:0]  addr_lo,
  input  logic [DATA_W-1:0] mem_word,
  input  logic [DATA_W-1:0] old_rt,
  output logic              out_valid,
  output logic [DATA_W-1:0] wr_data,
  output logic              misalign
);
  ld_kind_e          kind;
  logic              sign_ext;
  logic              mis_c;
  logic [7:0]        byte_v;
  logic [15:0]       half_v;
  logic [DATA_W-1:0] left_v;
  logic [DATA_W-1:0] right_v;
  logic [DATA_W-1:0] data_c;

  ld_decode #(.OFS_W(OFS_W)) u_dec (
    .op(op), .ofs(addr_lo), .kind(kind), .sign_ext(sign_ext), .misalign(mis_c)
  );

  ld_lane_pick #(.DATA_W(DATA_W)) u_pick (
    .word(mem_word), .ofs(addr_lo), .byte_o(byte_v), .half_o(half_v)
  );

  ld_partial_merge #(.DATA_W(DATA_W)) u_merge (
    .word(mem_word), .old_v(old_rt), .ofs(addr_lo),
    .left_o(left_v), .right_o(right_v)
  );

  always_comb begin
    unique case (kind)
      KIND_BYTE:  data_c = {{(DATA_W-8){sign_ext & byte_v[7]}}, byte_v};
      KIND_HALF:  data_c = {{(DATA_W-16){sign_ext & half_v[15]}}, half_v};
      KIND_WORD:  data_c = mem_word;
      KIND_LEFT:  data_c = left_v;
      KIND_RIGHT: data_c = right_v;
      default:    data_c = old_rt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      wr_data   <= '0;
      misalign  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        wr_data  <= data_c;
        misalign <= mis_c;
      end
    end
  end
endmodule

// File: rtl/ld_align_be_chk.sv
module ld_align_be_chk
  import ld_align_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [5:0]  op,
  input logic [1:0]  addr_lo,
  input logic [31:0] mem_word,
  input logic [31:0] old_rt,
  input logic        out_valid,
  input logic [31:0] wr_data,
  input logic        misalign
);
  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_drop_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_hold_idle_R12: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(wr_data) && $stable(misalign)));
  assert_no_flag_other_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op != OPC_HALF_S && op != OPC_HALF_U && op != OPC_WORD
     && op != OPC_LINKED) |=> !misalign);
  assert_ubyte_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OPC_BYTE_U) |=> (wr_data[31:8] == 24'd0));
  assert_sbyte_sign_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OPC_BYTE_S) |=> (wr_data[31:8] == {24{wr_data[7]}}));
  assert_left_full_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OPC_LEFT && addr_lo == 2'd0) |=> (wr_data == $past(mem_word)));
  assert_right_keep_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OPC_RIGHT && addr_lo == 2'd0) |=> (wr_data == $past(old_rt)));
endmodule

bind ld_align_be ld_align_be_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .addr_lo(addr_lo),
  .mem_word(mem_word), .old_rt(old_rt), .out_valid(out_valid),
  .wr_data(wr_data), .misalign(misalign)
);

// File: tb/tb_ld_align_be.sv
module tb_ld_align_be;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [5:0]  op;
  logic [1:0]  addr_lo;
  logic [31:0] mem_word;
  logic [31:0] old_rt;
  logic        out_valid;
  logic [31:0] wr_data;
  logic        misalign;

  typedef struct {
    logic [31:0] data;
    logic        mis;
    string       dtag;
    string       mtag;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ld_align_be dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .addr_lo(addr_lo),
    .mem_word(mem_word), .old_rt(old_rt), .out_valid(out_valid),
    .wr_data(wr_data), .misalign(misalign)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Model built from byte lanes: index 0 is the most significant byte.
  function automatic exp_t model(input logic [5:0] o, input logic [1:0] k,
                                 input logic [31:0] w, input logic [31:0] r);
    exp_t e;
    logic [7:0] mb [4];
    logic [7:0] rb [4];
    logic [7:0] ob [4];
    logic [15:0] h;
    for (int i = 0; i < 4; i++) begin
      mb[i] = w[31-8*i -: 8];
      rb[i] = r[31-8*i -: 8];
      ob[i] = rb[i];
    end
    h = k[1] ? {mb[2], mb[3]} : {mb[0], mb[1]};
    e.mis  = 1'b0;
    e.mtag = "R10";
    case (o)
      6'd32: begin e.data = {{24{mb[k][7]}}, mb[k]}; e.dtag = "R3"; end
      6'd36: begin e.data = {24'd0, mb[k]};          e.dtag = "R4"; end
      6'd33: begin e.data = {{16{h[15]}}, h}; e.dtag = "R5"; e.mis = k[0]; end
      6'd37: begin e.data = {16'd0, h};       e.dtag = "R6"; e.mis = k[0]; end
      6'd35, 6'd48: begin e.data = w; e.dtag = "R7"; e.mis = (k != 2'd0); end
      6'd34: begin
        for (int i = 0; i < 4; i++) if (i + int'(k) < 4) ob[i] = mb[i + int'(k)];
        e.data = {ob[0], ob[1], ob[2], ob[3]}; e.dtag = "R8";
      end
      6'd38: begin
        for (int i = 0; i < 4; i++) if (i >= 4 - int'(k)) ob[i] = mb[i - (4 - int'(k))];
        e.data = {ob[0], ob[1], ob[2], ob[3]}; e.dtag = "R9";
      end
      default: begin e.data = r; e.dtag = "R11"; e.mtag = "R11"; end
    endcase
    return e;
  endfunction

  task automatic send(input logic [5:0] o, input logic [1:0] k,
                      input logic [31:0] w, input logic [31:0] r);
    @(negedge clk);
    in_valid = 1'b1; op = o; addr_lo = k; mem_word = w; old_rt = r;
    exp_q.push_back(model(o, k, w, r));
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; op = 6'($urandom); addr_lo = 2'($urandom);
    mem_word = $urandom; old_rt = $urandom;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    #1;
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        check("R2 unexpected out_valid", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.dtag, wr_data, e.data);
        check(e.mtag, {31'd0, misalign}, {31'd0, e.mis});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [5:0] ops [10];
    logic [31:0] last;
    ops = '{6'd32, 6'd33, 6'd34, 6'd35, 6'd36, 6'd37, 6'd38, 6'd48, 6'd15, 6'd40};
    rst = 1'b1; in_valid = 1'b0; op = '0; addr_lo = '0; mem_word = '0; old_rt = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 out_valid", {31'd0, out_valid}, 32'd0);
    check("R1 wr_data", wr_data, 32'd0);
    check("R1 misalign", {31'd0, misalign}, 32'd0);
    rst = 1'b0;

    for (int rnd = 0; rnd < 4; rnd++) begin
      for (int oi = 0; oi < 10; oi++) begin
        for (int k = 0; k < 4; k++) begin
          logic [31:0] w, r;
          if (rnd == 0) begin w = 32'h80FF_7F01; r = 32'hA5A5_5A5A; end
          else if (rnd == 1) begin w = 32'h7F80_01FE; r = 32'h0123_4567; end
          else begin w = $urandom; r = $urandom; end
          send(ops[oi], 2'(k), w, r);
        end
      end
    end

    // R12 / R2: idle cycles hold the result and drop out_valid
    send(6'd33, 2'd2, 32'h1234_F678, 32'h0);
    last = 32'hFFFF_F678;
    idle();
    idle();
    #2;
    check("R2 out_valid low when idle", {31'd0, out_valid}, 32'd0);
    check("R12 wr_data held", wr_data, last);
    check("R12 misalign held", {31'd0, misalign}, 32'd0);

    repeat (4) @(negedge clk);
    #2;
    check("R2 all results delivered", exp_q.size(), 32'd0);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule